// File: doc/BRIEF.md
# UART Receive Time-out and Interrupt Identification

This block watches the receive side of a UART for characters that sit in the receive FIFO below the trigger level with no new traffic arriving. It measures silence in 16x oversampling ticks against a limit of four whole character times. That limit is computed from the current frame format: data length, parity and a stop length of 1, 1.5 or 2 bits. The silence measurement starts again at every stop-bit centre and every receive-buffer read.

The block also merges every interrupt source into one line. It reports a single identification code for whichever pending source ranks highest. A lower source shows only after every source above it has gone. The block keeps its own transmit-holding-empty flag, which is set out of reset, and it keeps its own time-out flag.

Top module: `uart_rx_timeout_irq`

## Requirements
- R1: One character time in ticks is 16 × (1 start + data bits + 1 if parity is enabled) plus the stop length: 16, 24 or 32 ticks. Data bits are 5 + `data_len_sel`. The `stop_sel` field selects the stop length: 0 gives 1 bit, 1 gives 1.5 bits, and 2 or 3 give 2 bits. The time-out limit is four character times.
- R2: With a non-empty FIFO and no restart, the time-out flag is clear after limit−1 ticks and set after exactly limit ticks, fractional stop lengths included.
- R3: No time-out is raised while `fifo_count` is 0. A time-out flag that is already set clears the cycle after the FIFO becomes empty.
- R4: A `stop_centre` strobe restarts the silence count from zero.
- R5: An `rhr_read` strobe restarts the silence count and clears the time-out flag.
- R6: Receive-data-available is pending when `fifo_count` ≥ `trig_level` and the count is non-zero. Both receive-data-available and time-out are gated by `ier_rx`.
- R7: `int_id` reports the highest pending source only. The order is line status (0x6), then receive data (0x4), then time-out (0xC), then transmit-empty (0x2), then modem status (0x0). The code 0x1 means that nothing is pending. Receive data and time-out share a level, and 0x4 is shown when both are pending.
- R8: The transmit-empty flag is set by reset and on each rising edge of `thr_empty`. It clears on `thr_write`, or on `iir_read` while 0x2 is the reported code. It is reported only when `ier_thre` is 1.
- R9: `irq` is 1 exactly when `int_id` differs from 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse per 16x sample tick |
| data_len_sel | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present |
| stop_sel | input | 2 | Stop length: 0 = 1, 1 = 1.5, 2/3 = 2 bits |
| stop_centre | input | 1 | Strobe at the centre of a received stop bit |
| rhr_read | input | 1 | Strobe on a receive-buffer read |
| fifo_count | input | CNT_W | Receive FIFO fill level |
| trig_level | input | CNT_W | Receive trigger level |
| thr_empty | input | 1 | Transmit holding register empty |
| thr_write | input | 1 | Strobe on a transmit holding register write |
| iir_read | input | 1 | Strobe on an identification register read |
| ier_ls | input | 1 | Line-status interrupt enable |
| ier_rx | input | 1 | Receive-data/time-out interrupt enable |
| ier_thre | input | 1 | Transmit-empty interrupt enable |
| ier_ms | input | 1 | Modem-status interrupt enable |
| ls_pending | input | 1 | Line-status condition pending |
| ms_pending | input | 1 | Modem-status condition pending |
| irq | output | 1 | Interrupt request |
| int_id | output | 4 | Identification code of the top pending source |

## Verification
The assertions assume several things about the inputs. Strobes last one clock cycle. `trig_level` is at least 1. `fifo_count` changes only through the receive path around it. The frame format holds still while a silence interval is being measured.

The stimulus respects these assumptions. Each scenario sets the format and the FIFO level before it issues a restarting `rhr_read`. Ticks are pulsed on alternate cycles. Every strobe is raised for exactly one cycle, between clock edges.

// File: rtl/uart_irq_pkg.sv
// Package: shared identification codes for the UART interrupt logic.
// Assumes a 4-bit identification field with bit 0 set meaning "nothing pending".
package uart_irq_pkg;
    typedef enum logic [3:0] {
        ID_NONE = 4'h1,
        ID_LS   = 4'h6,
        ID_RDA  = 4'h4,
        ID_RTO  = 4'hC,
        ID_THRE = 4'h2,
        ID_MS   = 4'h0
    } irq_id_e;

    // Stop length in half-bit units for a stop-select field value.
    function automatic logic [2:0] stop_halves(input logic [1:0] sel);
        case (sel)
            2'd0:    stop_halves = 3'd2;
            2'd1:    stop_halves = 3'd3;
            default: stop_halves = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/frame_time_calc.sv
// Module: frame_time_calc
// Turns the live frame format into the silence limit in 16x ticks:
// TO_CHARS character times, each made of start, data, optional parity and
// stop bits. Purely combinational, so a format change takes effect at once.
// Assumes TICKS_PER_BIT is even so that half-bit stop lengths are whole ticks.
module frame_time_calc
    import uart_irq_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int TO_CHARS      = 4,
    parameter int LIM_W         = 10
) (
    input  logic [1:0]       data_len_sel,
    input  logic             parity_en,
    input  logic [1:0]       stop_sel,
    output logic [LIM_W-1:0] limit
);
    localparam int HALF_SCALE = (TICKS_PER_BIT / 2) * TO_CHARS;

    logic [4:0] half_bits;

    // Count the frame length in half-bit units, then scale to ticks.
    always_comb begin
        half_bits = 5'd12                                  // start + 5 data bits
                  + {2'b00, data_len_sel, 1'b0}            // extra data bits
                  + {3'b000, parity_en, 1'b0}              // parity bit
                  + {2'b00, stop_halves(stop_sel)};        // stop bits
        limit = LIM_W'(half_bits) * LIM_W'(HALF_SCALE);
    end
endmodule

// File: rtl/rx_timeout_counter.sv
// Module: rx_timeout_counter
// Measures receive-line silence in ticks while the FIFO holds data and raises
// a sticky time-out flag when the silence reaches the limit.
// Assumes strobes last one cycle and the limit is at least 1.
module rx_timeout_counter #(
    parameter int LIM_W = 10,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic [LIM_W-1:0] limit,
    input  logic             stop_centre,
    input  logic             rhr_read,
    input  logic [CNT_W-1:0] fifo_count,
    output logic             timeout
);
    logic [LIM_W-1:0] silence;
    logic             fifo_empty;

    assign fifo_empty = (fifo_count == '0);

    // Count ticks of silence; restart on stop centre, read or empty FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            silence <= '0;
            timeout <= 1'b0;
        end else if (stop_centre || rhr_read || fifo_empty) begin
            silence <= '0;
            if (rhr_read || fifo_empty) timeout <= 1'b0;
        end else if (tick16 && !timeout) begin
            if (silence >= limit - LIM_W'(1)) begin
                silence <= '0;
                timeout <= 1'b1;
            end else begin
                silence <= silence + LIM_W'(1);
            end
        end
    end

    AST_TO_EMPTY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |=> !timeout);                                    // R3
    AST_TO_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        rhr_read |=> !timeout);                                      // R5
    AST_TO_RISE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> $past(tick16) && $past(!fifo_empty));     // R2
endmodule

// File: rtl/irq_prioritizer.sv
// Module: irq_prioritizer
// Holds the transmit-empty flag and selects the single highest pending
// interrupt source, producing its code and the interrupt line.
// Assumes trig_level >= 1 and one-cycle read/write strobes.
module irq_prioritizer
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [CNT_W-1:0] trig_level,
    input  logic             timeout,
    input  logic             thr_empty,
    input  logic             thr_write,
    input  logic             iir_read,
    input  logic             ier_ls,
    input  logic             ier_rx,
    input  logic             ier_thre,
    input  logic             ier_ms,
    input  logic             ls_pending,
    input  logic             ms_pending,
    output logic             irq,
    output irq_id_e          int_id
);
    logic thre_flag;
    logic thr_empty_q;
    logic rda;

    assign rda = (fifo_count != '0) && (fifo_count >= trig_level);

    // Track the transmit-empty source: set at reset and on empty rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thre_flag   <= 1'b1;
            thr_empty_q <= 1'b1;
        end else begin
            thr_empty_q <= thr_empty;
            if (thr_write || (iir_read && int_id == ID_THRE))
                thre_flag <= 1'b0;
            else if (thr_empty && !thr_empty_q)
                thre_flag <= 1'b1;
        end
    end

    // Pick the highest-ranked enabled pending source.
    always_comb begin
        if (ier_ls && ls_pending)        int_id = ID_LS;
        else if (ier_rx && rda)          int_id = ID_RDA;
        else if (ier_rx && timeout)      int_id = ID_RTO;
        else if (ier_thre && thre_flag)  int_id = ID_THRE;
        else if (ier_ms && ms_pending)   int_id = ID_MS;
        else                             int_id = ID_NONE;
        irq = (int_id != ID_NONE);
    end

    AST_THRE_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        thr_write |=> !thre_flag);                                   // R8
    AST_LS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_ls && ls_pending) |-> (int_id == ID_LS));               // R7
    AST_RDA_OVER_TO: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_rx && rda && !(ier_ls && ls_pending)) |-> (int_id == ID_RDA)); // R6
endmodule

// File: rtl/uart_rx_timeout_irq.sv
// Module: uart_rx_timeout_irq (top)
// Receive time-out detection and prioritised interrupt identification for a
// UART. Assumes the surrounding receiver supplies a 16x tick, the FIFO level
// and one-cycle strobes for stop centres and register accesses.
module uart_rx_timeout_irq
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH    = 16,
    parameter int TICKS_PER_BIT = 16,
    parameter int TO_CHARS      = 4,
    parameter int CNT_W         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic [1:0]       data_len_sel,
    input  logic             parity_en,
    input  logic [1:0]       stop_sel,
    input  logic             stop_centre,
    input  logic             rhr_read,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [CNT_W-1:0] trig_level,
    input  logic             thr_empty,
    input  logic             thr_write,
    input  logic             iir_read,
    input  logic             ier_ls,
    input  logic             ier_rx,
    input  logic             ier_thre,
    input  logic             ier_ms,
    input  logic             ls_pending,
    input  logic             ms_pending,
    output logic             irq,
    output logic [3:0]       int_id
);
    localparam int MAX_BITS = 12;   // start + 8 data + parity + 2 stop
    localparam int MAX_LIM  = MAX_BITS * TICKS_PER_BIT * TO_CHARS;
    localparam int LIM_W    = $clog2(MAX_LIM + 1);

    logic [LIM_W-1:0] limit;
    logic             timeout;
    irq_id_e          id_sel;

    frame_time_calc #(
        .TICKS_PER_BIT(TICKS_PER_BIT),
        .TO_CHARS     (TO_CHARS),
        .LIM_W        (LIM_W)
    ) u_calc (
        .data_len_sel(data_len_sel),
        .parity_en   (parity_en),
        .stop_sel    (stop_sel),
        .limit       (limit)
    );

    rx_timeout_counter #(
        .LIM_W(LIM_W),
        .CNT_W(CNT_W)
    ) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick16     (tick16),
        .limit      (limit),
        .stop_centre(stop_centre),
        .rhr_read   (rhr_read),
        .fifo_count (fifo_count),
        .timeout    (timeout)
    );

    irq_prioritizer #(
        .CNT_W(CNT_W)
    ) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_count(fifo_count),
        .trig_level(trig_level),
        .timeout   (timeout),
        .thr_empty (thr_empty),
        .thr_write (thr_write),
        .iir_read  (iir_read),
        .ier_ls    (ier_ls),
        .ier_rx    (ier_rx),
        .ier_thre  (ier_thre),
        .ier_ms    (ier_ms),
        .ls_pending(ls_pending),
        .ms_pending(ms_pending),
        .irq       (irq),
        .int_id    (id_sel)
    );

    assign int_id = id_sel;

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (int_id != 4'h1));                                    // R9
endmodule

// File: tb/tb_uart_rx_timeout_irq.sv
`timescale 1ns/1ps
module tb_uart_rx_timeout_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic [1:0] data_len_sel = 2'd3;
    logic       parity_en = 1'b0;
    logic [1:0] stop_sel = 2'd0;
    logic       stop_centre = 1'b0;
    logic       rhr_read = 1'b0;
    logic [4:0] fifo_count = '0;
    logic [4:0] trig_level = 5'd8;
    logic       thr_empty = 1'b1;
    logic       thr_write = 1'b0;
    logic       iir_read = 1'b0;
    logic       ier_ls = 1'b0, ier_rx = 1'b0, ier_thre = 1'b0, ier_ms = 1'b0;
    logic       ls_pending = 1'b0, ms_pending = 1'b0;
    logic       irq;
    logic [3:0] int_id;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_rx_timeout_irq dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16),
        .data_len_sel(data_len_sel), .parity_en(parity_en), .stop_sel(stop_sel),
        .stop_centre(stop_centre), .rhr_read(rhr_read),
        .fifo_count(fifo_count), .trig_level(trig_level),
        .thr_empty(thr_empty), .thr_write(thr_write), .iir_read(iir_read),
        .ier_ls(ier_ls), .ier_rx(ier_rx), .ier_thre(ier_thre), .ier_ms(ier_ms),
        .ls_pending(ls_pending), .ms_pending(ms_pending),
        .irq(irq), .int_id(int_id)
    );

    task automatic check_id(input string req, input logic [3:0] exp);
        checks++;
        if (int_id !== exp) begin
            errors++;
            $display("FAIL %s: int_id actual=0x%0h expected=0x%0h", req, int_id, exp);
        end
        checks++;
        if (irq !== (exp != 4'h1)) begin
            errors++;
            $display("FAIL R9: irq actual=%0b expected=%0b", irq, (exp != 4'h1));
        end
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick16 = 1'b1;
            @(negedge clk); tick16 = 1'b0;
        end
    endtask

    // R1/R2: the limit is derived from the frame; check the boundary tick.
    task automatic t_timeout(input logic [1:0] dl, input logic par,
                             input logic [1:0] st, input int halves);
        int lim;
        lim = ((6 + dl + par) * 16 + halves * 8) * 4;
        data_len_sel = dl; parity_en = par; stop_sel = st;
        fifo_count = 5'd1; trig_level = 5'd8; ier_rx = 1'b1;
        pulse(rhr_read);
        ticks(lim - 1);
        check_id("R2 before limit", 4'h1);
        ticks(1);
        check_id("R1 R2 at limit", 4'hC);
        pulse(rhr_read);
        check_id("R5 read clears", 4'h1);
    endtask

    // R4: a stop-centre strobe restarts the measurement.
    task automatic t_stop_restart();
        data_len_sel = 2'd0; parity_en = 1'b0; stop_sel = 2'd0; // 448 ticks
        fifo_count = 5'd2; ier_rx = 1'b1;
        pulse(rhr_read);
        ticks(400);
        pulse(stop_centre);
        ticks(447);
        check_id("R4 restarted", 4'h1);
        ticks(1);
        check_id("R4 full after restart", 4'hC);
        pulse(rhr_read);
    endtask

    // R3: an empty FIFO blocks time-out and clears a raised one.
    task automatic t_empty();
        data_len_sel = 2'd0; parity_en = 1'b0; stop_sel = 2'd0;
        fifo_count = 5'd0; ier_rx = 1'b1;
        ticks(800);
        check_id("R3 empty no timeout", 4'h1);
        fifo_count = 5'd1;
        pulse(rhr_read);
        ticks(448);
        check_id("R3 timeout with data", 4'hC);
        @(negedge clk); fifo_count = 5'd0;
        @(negedge clk);
        check_id("R3 cleared on empty", 4'h1);
    endtask

    // R6: receive-data-available threshold and enable gating.
    task automatic t_rda();
        trig_level = 5'd4; ier_rx = 1'b1;
        @(negedge clk); fifo_count = 5'd3;
        pulse(rhr_read);
        check_id("R6 below trigger", 4'h1);
        @(negedge clk); fifo_count = 5'd4;
        @(negedge clk);
        check_id("R6 at trigger", 4'h4);
        ier_rx = 1'b0;
        @(negedge clk);
        check_id("R6 disabled", 4'h1);
        ier_rx = 1'b1;
        // same level: data-available shown over time-out
        @(negedge clk); fifo_count = 5'd1; trig_level = 5'd1;
        data_len_sel = 2'd0; stop_sel = 2'd0;
        pulse(rhr_read);
        ticks(448);
        check_id("R7 data over timeout", 4'h4);
        trig_level = 5'd8;
        @(negedge clk);
        check_id("R7 timeout shown", 4'hC);
        pulse(rhr_read);
        fifo_count = 5'd0;
    endtask

    // R7/R8: ranking of all sources and the transmit-empty flag lifecycle.
    task automatic t_priority();
        ier_ls = 1'b1; ier_rx = 1'b1; ier_thre = 1'b1; ier_ms = 1'b1;
        ls_pending = 1'b1; ms_pending = 1'b1;
        trig_level = 5'd2; fifo_count = 5'd3;
        thr_empty = 1'b0;
        @(negedge clk); thr_empty = 1'b1;
        @(negedge clk);
        check_id("R7 line status top", 4'h6);
        ls_pending = 1'b0;
        @(negedge clk);
        check_id("R7 data next", 4'h4);
        fifo_count = 5'd0;
        @(negedge clk);
        check_id("R7 R8 tx empty next", 4'h2);
        pulse(thr_write);
        check_id("R8 write clears", 4'h0);
        ms_pending = 1'b0;
        @(negedge clk);
        check_id("R7 none", 4'h1);
        thr_empty = 1'b0;
        @(negedge clk); thr_empty = 1'b1;
        @(negedge clk);
        check_id("R8 set on rise", 4'h2);
        pulse(iir_read);
        check_id("R8 id read clears", 4'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_id("R8 reset none enabled", 4'h1);
        ier_thre = 1'b1;
        @(negedge clk);
        check_id("R8 empty after reset", 4'h2);
        pulse(iir_read);
        check_id("R8 cleared by id read", 4'h1);
        ier_thre = 1'b0;
        t_timeout(2'd3, 1'b0, 2'd0, 2);   // 8N1: 640 ticks
        t_timeout(2'd2, 1'b1, 2'd1, 3);   // 7 data, parity, 1.5 stop: 672
        t_timeout(2'd1, 1'b1, 2'd3, 4);   // 6 data, parity, 2 stop: 640
        t_stop_restart();
        t_empty();
        t_rda();
        t_priority();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule